// File: doc/BRIEF.md
# CAN Standard-Identifier Acceptance Filter

This block decides whether a received 11-bit CAN identifier should be kept, and which filter slot claims it. Every slot holds a filter identifier and is paired with an acceptance mask. A mask bit of 1 makes the matching identifier bit significant, and a mask bit of 0 turns that bit into a don't-care. One filter with a partly cleared mask can therefore accept a whole range of identifiers. For example, filter 0x404 with mask 0x7FC accepts 0x404 to 0x407, and filter 0x420 with mask 0x7F0 accepts 0x420 to 0x42F.

The block has two arrangements. In mailbox mode, each mailbox identifier is compared using the dedicated mask of the same number. In queue mode, a separate filter table of programmable length is searched as well. Table entries below ten borrow the dedicated mask of the same number, and the remaining entries share one global queue mask. The dedicated masks that the table borrows take their mailboxes out of the search. Every other mailbox keeps its own mask and stays active. For example, mailbox 20 still filters with mask 20 while the queue is on.

Software sets up the block through a simple write-only register port. The receive path presents an identifier with a one-cycle strobe. One cycle later the block returns a registered verdict: an accept flag, a flag saying whether a table entry won, and the index of the winner.

Top module: `can_id_filter`

## Requirements
- R1: An identifier matches a slot when every identifier bit under a mask bit of 1 equals the filter bit. Bits under a mask bit of 0 are ignored. Filter 0x404 with mask 0x7FC accepts 0x407 and rejects 0x408.
- R2: With queue mode off, every mailbox n (0 to NUM_MB-1) is compared using dedicated mask n, and no table entry can win.
- R3: With queue mode on, table entries 0 to count-1 are active. Entry n below TBL_DED (10) uses dedicated mask n, and every later entry uses the global queue mask. A count above TBL_MAX is treated as TBL_MAX.
- R4: With queue mode on, mailbox n is left out of the search when n < min(count, TBL_DED). All other mailboxes stay active with their own dedicated mask.
- R5: A matching table entry beats any matching mailbox. Within each group, the lowest matching index wins. `hit_idx` reports that index, and `from_tbl` is 1 when the winner is a table entry.
- R6: `res_valid` is high exactly in the cycle after `id_valid`. `accept`, `from_tbl` and `hit_idx` are updated only by a strobe and hold their values otherwise.
- R7: When nothing matches, `accept`, `from_tbl` and `hit_idx` are all 0.
- R8: A configuration write affects the next evaluation. A write in the same cycle as a strobe does not change that strobe's verdict.
- R9: Reset does the following:
  - sets every dedicated mask and the global mask to 0x7FF;
  - sets every mailbox and table identifier to 0;
  - turns queue mode off and sets the count to 0;
  - clears all outputs.
- R10: The register map is as follows:
  - Address 0x00 is control: bit 15 is the queue enable and bits 6:0 are the entry count.
  - Address 0x01 is the global mask.
  - Address 0x40+n is dedicated mask n.
  - Address 0x80+n is mailbox identifier n.
  - Address 0xC0+n is table identifier n.
  - Masks and identifiers take data bits 10:0.
  - Writes to any other address, or to an index past the implemented slots, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| id_valid | input | 1 | Strobe: `id_in` holds an identifier to evaluate |
| id_in | input | 11 | Received standard identifier |
| res_valid | output | 1 | Verdict valid pulse, one cycle after `id_valid` |
| accept | output | 1 | Identifier accepted by some active slot |
| from_tbl | output | 1 | Winner is a queue table entry (0: mailbox) |
| hit_idx | output | IDX_W (5) | Index of the winning slot |

## Verification
The bench builds the block with its defaults: 32 mailboxes, a 16-entry queue table and 10 borrowed masks. This is the smallest arrangement in which an active mailbox keeps its own mask beyond the borrowed ones, such as mailbox 20. It also contains table entries that fall back to the global mask, and a table count that can be programmed past the table size to exercise clamping. With 32 mailboxes, some mailbox indices lie beyond every table index, so the priority between the two groups is tested in both directions.

// File: rtl/can_filt_pkg.sv
// Package: shared widths, register-map constants and the masked-compare
// helper used by the acceptance filter.
package can_filt_pkg;

    localparam int ID_W   = 11;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 7;

    typedef logic [ID_W-1:0] can_id_t;

    localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] A_GMASK = 8'h01;

    localparam logic [1:0] RG_DMASK = 2'b01;
    localparam logic [1:0] RG_MBID  = 2'b10;
    localparam logic [1:0] RG_TBID  = 2'b11;

    localparam int CTRL_EN_BIT = 15;

    localparam can_id_t MASK_ALL = 11'h7FF;

    // True when id equals flt in every bit the mask marks as significant.
    function automatic logic masked_eq(input can_id_t id, input can_id_t flt,
                                       input can_id_t msk);
        return ((id ^ flt) & msk) == '0;
    endfunction

endpackage

// File: rtl/can_filt_cfg.sv
// Configuration register file for the acceptance filter.
// Decodes the write port into control, global mask, dedicated masks,
// mailbox identifiers and table identifiers.
// Assumes NUM_MB <= 64 and TBL_MAX <= 64 (6-bit offset within a region).
module can_filt_cfg
    import can_filt_pkg::*;
#(
    parameter int NUM_MB  = 32,
    parameter int TBL_MAX = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic                          tbl_en,
    output logic [CNT_W-1:0]              tbl_cnt,
    output can_id_t                       gmask,
    output logic [NUM_MB-1:0][ID_W-1:0]   dmask,
    output logic [NUM_MB-1:0][ID_W-1:0]   mb_id,
    output logic [TBL_MAX-1:0][ID_W-1:0]  tb_id
);

    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(TBL_MAX);

    logic [1:0]       region;
    logic [5:0]       offs;
    logic [CNT_W-1:0] cnt_req;
    logic             unused_wdata;

    assign region       = addr[7:6];
    assign offs         = addr[5:0];
    assign cnt_req      = wdata[CNT_W-1:0];
    assign unused_wdata = ^wdata[CTRL_EN_BIT-1:ID_W];

    // Control register: queue enable and clamped entry count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_en  <= 1'b0;
            tbl_cnt <= '0;
        end else if (we && addr == A_CTRL) begin
            tbl_en  <= wdata[CTRL_EN_BIT];
            tbl_cnt <= (cnt_req > CNT_CAP) ? CNT_CAP : cnt_req;
        end
    end

    // Global mask shared by the table entries past the borrowed range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gmask <= MASK_ALL;
        end else if (we && addr == A_GMASK) begin
            gmask <= wdata[ID_W-1:0];
        end
    end

    for (genvar n = 0; n < NUM_MB; n++) begin : g_mb
        // Dedicated mask n, reset to all-significant.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dmask[n] <= MASK_ALL;
            end else if (we && region == RG_DMASK && offs == 6'(n)) begin
                dmask[n] <= wdata[ID_W-1:0];
            end
        end

        // Mailbox identifier n.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mb_id[n] <= '0;
            end else if (we && region == RG_MBID && offs == 6'(n)) begin
                mb_id[n] <= wdata[ID_W-1:0];
            end
        end
    end

    for (genvar n = 0; n < TBL_MAX; n++) begin : g_tb
        // Table identifier n.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tb_id[n] <= '0;
            end else if (we && region == RG_TBID && offs == 6'(n)) begin
                tb_id[n] <= wdata[ID_W-1:0];
            end
        end
    end

endmodule

// File: rtl/can_filt_match.sv
// Parallel compare array: one masked compare per mailbox and per table
// entry, with the mode- and index-dependent mask selection and the
// active-slot gating. Purely combinational.
// Assumes TBL_DED <= NUM_MB and TBL_DED <= TBL_MAX.
module can_filt_match
    import can_filt_pkg::*;
#(
    parameter int NUM_MB  = 32,
    parameter int TBL_MAX = 16,
    parameter int TBL_DED = 10
) (
    input  can_id_t                       id,
    input  logic                          tbl_en,
    input  logic [CNT_W-1:0]              tbl_cnt,
    input  can_id_t                       gmask,
    input  logic [NUM_MB-1:0][ID_W-1:0]   dmask,
    input  logic [NUM_MB-1:0][ID_W-1:0]   mb_id,
    input  logic [TBL_MAX-1:0][ID_W-1:0]  tb_id,
    output logic [NUM_MB-1:0]             mb_hit,
    output logic [TBL_MAX-1:0]            tb_hit
);

    localparam logic [CNT_W-1:0] DED_CAP = CNT_W'(TBL_DED);

    logic [CNT_W-1:0] borrowed;

    // Number of dedicated masks taken by the table (0 in mailbox mode).
    always_comb begin
        if (!tbl_en)                 borrowed = '0;
        else if (tbl_cnt < DED_CAP)  borrowed = tbl_cnt;
        else                         borrowed = DED_CAP;
    end

    for (genvar n = 0; n < TBL_MAX; n++) begin : g_tb
        can_id_t emask;
        if (n < TBL_DED) begin : g_ded
            assign emask = dmask[n];
        end else begin : g_glb
            assign emask = gmask;
        end
        assign tb_hit[n] = tbl_en && (CNT_W'(n) < tbl_cnt)
                           && masked_eq(id, tb_id[n], emask);
    end

    for (genvar n = 0; n < NUM_MB; n++) begin : g_mb
        assign mb_hit[n] = (CNT_W'(n) >= borrowed)
                           && masked_eq(id, mb_id[n], dmask[n]);
    end

endmodule

// File: rtl/can_filt_prio.sv
// Lowest-index-first priority encoder. Reports whether any request bit is
// set and the index of the lowest one; index is 0 when none is set.
module can_filt_prio #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/can_id_filter.sv
// Top of the standard-identifier acceptance filter.
// Evaluates id_in against all active slots on id_valid and registers the
// verdict: table entries outrank mailboxes, lowest index wins in a group.
// Assumes a single clock, synchronous active-low reset, and parameters
// satisfying TBL_DED <= TBL_MAX <= 64, TBL_DED <= NUM_MB <= 64, TBL_MAX >= 2.
module can_id_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_MB  = 32,
    parameter int TBL_MAX = 16,
    parameter int TBL_DED = 10,
    localparam int IDX_W  = $clog2((NUM_MB > TBL_MAX) ? NUM_MB : TBL_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              id_valid,
    input  logic [10:0]       id_in,
    output logic              res_valid,
    output logic              accept,
    output logic              from_tbl,
    output logic [IDX_W-1:0]  hit_idx
);

    logic                          tbl_en_q;
    logic [CNT_W-1:0]              tbl_cnt_q;
    can_id_t                       gmask_q;
    logic [NUM_MB-1:0][ID_W-1:0]   dmask_q;
    logic [NUM_MB-1:0][ID_W-1:0]   mb_id_q;
    logic [TBL_MAX-1:0][ID_W-1:0]  tb_id_q;

    logic [NUM_MB-1:0]  mb_hit;
    logic [TBL_MAX-1:0] tb_hit;
    logic               mb_any;
    logic               tb_any;
    logic [IDX_W-1:0]   mb_win;
    logic [IDX_W-1:0]   tb_win;

    can_filt_cfg #(
        .NUM_MB  (NUM_MB),
        .TBL_MAX (TBL_MAX)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .tbl_en  (tbl_en_q),
        .tbl_cnt (tbl_cnt_q),
        .gmask   (gmask_q),
        .dmask   (dmask_q),
        .mb_id   (mb_id_q),
        .tb_id   (tb_id_q)
    );

    can_filt_match #(
        .NUM_MB  (NUM_MB),
        .TBL_MAX (TBL_MAX),
        .TBL_DED (TBL_DED)
    ) u_match (
        .id      (id_in),
        .tbl_en  (tbl_en_q),
        .tbl_cnt (tbl_cnt_q),
        .gmask   (gmask_q),
        .dmask   (dmask_q),
        .mb_id   (mb_id_q),
        .tb_id   (tb_id_q),
        .mb_hit  (mb_hit),
        .tb_hit  (tb_hit)
    );

    can_filt_prio #(
        .W  (NUM_MB),
        .IW (IDX_W)
    ) u_prio_mb (
        .req (mb_hit),
        .any (mb_any),
        .idx (mb_win)
    );

    can_filt_prio #(
        .W  (TBL_MAX),
        .IW (IDX_W)
    ) u_prio_tb (
        .req (tb_hit),
        .any (tb_any),
        .idx (tb_win)
    );

    // Verdict register: captured on a strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            accept    <= 1'b0;
            from_tbl  <= 1'b0;
            hit_idx   <= '0;
        end else begin
            res_valid <= id_valid;
            if (id_valid) begin
                if (tb_any) begin
                    accept   <= 1'b1;
                    from_tbl <= 1'b1;
                    hit_idx  <= tb_win;
                end else if (mb_any) begin
                    accept   <= 1'b1;
                    from_tbl <= 1'b0;
                    hit_idx  <= mb_win;
                end else begin
                    accept   <= 1'b0;
                    from_tbl <= 1'b0;
                    hit_idx  <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/can_id_filter_chk.sv
// Assertion checker for can_id_filter, attached by bind. Observes the
// verdict outputs, the strobe and the stored queue enable.
module can_id_filter_chk #(
    parameter int NUM_MB  = 32,
    parameter int TBL_MAX = 16,
    parameter int IDX_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_valid,
    input logic             tbl_en,
    input logic             res_valid,
    input logic             accept,
    input logic             from_tbl,
    input logic [IDX_W-1:0] hit_idx
);

    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> res_valid); // R6
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |=> !res_valid); // R6
    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |=> ($stable(accept) && $stable(from_tbl) && $stable(hit_idx))); // R6
    AST_NOMATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> (hit_idx == '0 && !from_tbl)); // R7
    AST_TABLE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && !tbl_en) |=> !from_tbl); // R2
    AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (from_tbl ? (int'(hit_idx) < TBL_MAX) : (int'(hit_idx) < NUM_MB))); // R5
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !accept && !from_tbl && hit_idx == '0)); // R9

endmodule

bind can_id_filter can_id_filter_chk #(
    .NUM_MB  (NUM_MB),
    .TBL_MAX (TBL_MAX),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_valid  (id_valid),
    .tbl_en    (tbl_en_q),
    .res_valid (res_valid),
    .accept    (accept),
    .from_tbl  (from_tbl),
    .hit_idx   (hit_idx)
);

// File: tb/can_id_filter_tb.sv
`timescale 1ns/1ps
module can_id_filter_tb;

    localparam int NUM_MB  = 32;
    localparam int TBL_MAX = 16;
    localparam int TBL_DED = 10;
    localparam int IDX_W   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_addr = '0;
    logic [15:0]       cfg_wdata = '0;
    logic              id_valid = 1'b0;
    logic [10:0]       id_in = '0;
    logic              res_valid;
    logic              accept;
    logic              from_tbl;
    logic [IDX_W-1:0]  hit_idx;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    // Shadow of the programmed configuration, built from the register map.
    logic [10:0] s_dmask [NUM_MB];
    logic [10:0] s_mbid  [NUM_MB];
    logic [10:0] s_tbid  [TBL_MAX];
    logic [10:0] s_gmask;
    logic        s_en;
    int          s_cnt;

    always #2.5 clk = ~clk;

    can_id_filter #(
        .NUM_MB  (NUM_MB),
        .TBL_MAX (TBL_MAX),
        .TBL_DED (TBL_DED)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .id_valid  (id_valid),
        .id_in     (id_in),
        .res_valid (res_valid),
        .accept    (accept),
        .from_tbl  (from_tbl),
        .hit_idx   (hit_idx)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run exceeded cycle budget (act=%0d exp<=150000)", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic shadow_reset();
        for (int i = 0; i < NUM_MB; i++) begin
            s_dmask[i] = 11'h7FF;
            s_mbid[i]  = 11'h000;
        end
        for (int i = 0; i < TBL_MAX; i++) s_tbid[i] = 11'h000;
        s_gmask = 11'h7FF;
        s_en    = 1'b0;
        s_cnt   = 0;
    endtask

    function automatic void shadow_write(input logic [7:0] a, input logic [15:0] d);
        int off;
        off = int'(a[5:0]);
        if (a == 8'h00) begin
            s_en  = d[15];
            s_cnt = (int'(d[6:0]) > TBL_MAX) ? TBL_MAX : int'(d[6:0]);
        end else if (a == 8'h01) begin
            s_gmask = d[10:0];
        end else if (a[7:6] == 2'b01 && off < NUM_MB) begin
            s_dmask[off] = d[10:0];
        end else if (a[7:6] == 2'b10 && off < NUM_MB) begin
            s_mbid[off] = d[10:0];
        end else if (a[7:6] == 2'b11 && off < TBL_MAX) begin
            s_tbid[off] = d[10:0];
        end
    endfunction

    // Expected verdict packed as {accept, from_tbl, index[IDX_W-1:0]}.
    function automatic int expect_of(input logic [10:0] id);
        int lent;
        int lim;
        logic [10:0] m;
        if (s_en) begin
            for (int n = 0; n < s_cnt; n++) begin
                m = (n < TBL_DED) ? s_dmask[n] : s_gmask;
                if (((id ^ s_tbid[n]) & m) == 11'h000) return (3 << IDX_W) | n;
            end
        end
        lim  = (s_cnt < TBL_DED) ? s_cnt : TBL_DED;
        lent = s_en ? lim : 0;
        for (int n = lent; n < NUM_MB; n++) begin
            if (((id ^ s_mbid[n]) & s_dmask[n]) == 11'h000) return (2 << IDX_W) | n;
        end
        return 0;
    endfunction

    function automatic int got();
        return (int'(accept) << (IDX_W + 1)) | (int'(from_tbl) << IDX_W) | int'(hit_idx);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow_write(a, d);
    endtask

    task automatic eval(input logic [10:0] id, input string req);
        int exp;
        exp = expect_of(id);
        @(negedge clk);
        id_valid = 1'b1; id_in = id;
        @(negedge clk);
        id_valid = 1'b0;
        chk(res_valid == 1'b1, "R6 res_valid after strobe", int'(res_valid), 1);
        chk(got() == exp, req, got(), exp);
    endtask

    initial begin
        int exp;
        int held;
        logic [10:0] rid;
        shadow_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: outputs cleared after reset
        chk(res_valid == 0 && got() == 0, "R9 outputs after reset", got(), 0);
        // R9/R2: reset IDs are 0 with full masks, so ID 0 hits mailbox 0
        eval(11'h000, "R9 reset config accepts 0x000 at mailbox 0");
        if (got() != (2 << IDX_W)) chk(0, "R9 mailbox 0 verdict", got(), 2 << IDX_W);
        eval(11'h123, "R7 no match gives zero verdict");

        for (int n = 0; n < NUM_MB; n++) wr(8'h80 + 8'(n), 16'h600 + 16'(n));
        wr(8'h80 + 8'd3, 16'h404); wr(8'h40 + 8'd3, 16'h7FC);
        wr(8'h80 + 8'd7, 16'h420); wr(8'h40 + 8'd7, 16'h7F0);
        eval(11'h407, "R1 0x404/0x7FC accepts 0x407");
        chk(got() == ((2 << IDX_W) | 3), "R1 mailbox 3 wins", got(), (2 << IDX_W) | 3);
        eval(11'h408, "R1 0x404/0x7FC rejects 0x408");
        eval(11'h42F, "R2 mailbox 7 with its own mask");
        wr(8'h80 + 8'd9, 16'h405);
        eval(11'h405, "R5 lowest mailbox index wins");

        // Table setup: range filters, some entries on the global mask.
        begin
            logic [10:0] ids [16];
            logic [10:0] msk [10];
            ids = '{11'h402, 11'h403, 11'h404, 11'h408, 11'h410, 11'h420, 11'h430, 11'h440,
                    11'h448, 11'h449, 11'h44A, 11'h44B, 11'h44C, 11'h44F, 11'h450, 11'h000};
            msk = '{11'h7FF, 11'h7FF, 11'h7FC, 11'h7F8, 11'h7F0,
                    11'h7F0, 11'h7F0, 11'h7F8, 11'h7FF, 11'h7FF};
            for (int n = 0; n < 16; n++) wr(8'hC0 + 8'(n), {5'd0, ids[n]});
            for (int n = 0; n < 10; n++) wr(8'h40 + 8'(n), {5'd0, msk[n]});
        end
        wr(8'h80 + 8'd5, 16'h500);
        eval(11'h505, "R2 mailbox 5 active in mailbox mode");
        eval(11'h44C, "R2 table ignored while queue mode off");
        wr(8'h00, 16'h8010);
        eval(11'h44C, "R3 entry 12 via global mask");
        chk(got() == ((3 << IDX_W) | 12), "R3 table entry 12", got(), (3 << IDX_W) | 12);
        wr(8'h01, 16'h7F0);
        eval(11'h44D, "R3 global mask widens entry 10");
        wr(8'h80 + 8'd20, 16'h300); wr(8'h40 + 8'd20, 16'h7F0);
        eval(11'h30A, "R4 mailbox 20 keeps mask 20 in queue mode");
        chk(got() == ((2 << IDX_W) | 20), "R4 mailbox 20", got(), (2 << IDX_W) | 20);
        eval(11'h505, "R4 mailbox 5 excluded in queue mode");
        chk(accept == 1'b0, "R4 mailbox 5 excluded", int'(accept), 0);
        wr(8'h80 + 8'd25, 16'h402);
        eval(11'h402, "R5 table entry beats mailbox");
        wr(8'h00, 16'h8028);
        eval(11'h00F, "R3 count 40 clamps to 16, entry 15 active");
        wr(8'h00, 16'h800C);
        eval(11'h44C, "R3 count 12 disables entry 12");
        wr(8'h00, 16'h8004);
        eval(11'h505, "R4 count 4 frees mailbox 5");
        chk(got() == ((2 << IDX_W) | 5), "R4 mailbox 5 back", got(), (2 << IDX_W) | 5);

        // R8: write in the strobe cycle does not affect that strobe
        exp = expect_of(11'h111);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h80 + 8'd30; cfg_wdata = 16'h111;
        id_valid = 1'b1; id_in = 11'h111;
        @(negedge clk);
        cfg_we = 1'b0; id_valid = 1'b0;
        shadow_write(8'h80 + 8'd30, 16'h111);
        chk(got() == exp, "R8 same-cycle write unseen", got(), exp);
        eval(11'h111, "R8 write seen on next evaluation");

        // R10: unmapped and out-of-range writes change nothing
        wr(8'h05, 16'hFFFF);
        wr(8'h40 + 8'd40, 16'h000);
        wr(8'hC0 + 8'd20, 16'h123);
        eval(11'h505, "R10 unmapped writes ignored (control)");
        eval(11'h123, "R10 out-of-range table write ignored");

        // R6: verdict holds while no strobe arrives
        eval(11'h30A, "R6 setup");
        held = got();
        @(negedge clk); id_in = 11'h000;
        repeat (3) @(negedge clk);
        chk(got() == held, "R6 verdict held without strobe", got(), held);
        chk(res_valid == 1'b0, "R6 no valid without strobe", int'(res_valid), 0);

        // Random phase with fixed seed.
        void'($urandom(32'h5EED_C0DE));
        for (int it = 0; it < 600; it++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 12) begin
                int k;
                k = int'($urandom_range(0, 4));
                case (k)
                    0: wr(8'h00, {1'b1 ^ ($urandom_range(0, 3) == 0), 8'd0, 7'($urandom_range(0, 24))});
                    1: wr(8'h01, {5'd0, 11'h7FF << $urandom_range(0, 5)});
                    2: wr(8'h40 + 8'($urandom_range(0, NUM_MB - 1)), {5'd0, 11'h7FF << $urandom_range(0, 6)});
                    3: wr(8'h80 + 8'($urandom_range(0, NUM_MB - 1)), 16'($urandom_range(0, 2047)));
                    default: wr(8'hC0 + 8'($urandom_range(0, TBL_MAX - 1)), 16'($urandom_range(0, 2047)));
                endcase
            end else begin
                if (r < 50) rid = s_mbid[$urandom_range(0, NUM_MB - 1)];
                else if (r < 85) rid = s_tbid[$urandom_range(0, TBL_MAX - 1)];
                else rid = 11'($urandom_range(0, 2047));
                rid = rid ^ (11'(1) << $urandom_range(0, 10)) & {11{r[0]}};
                eval(rid, "R5 random verdict");
            end
        end

        summary();
        $finish;
    end

endmodule